// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block sets the pace of the core and the peripherals of a small microcontroller. The whole chip runs from one oscillator clock. The block does not gate that clock. It produces two clock-enable strobes instead: one for the CPU and one for the peripherals. In Normal Run both strobes are high on every cycle. In Slow mode both pulse once every 2, 4, 8 or 16 cycles. The rate comes from a 2-bit divider code that software writes together with a slow-enable bit.

A wait-for-interrupt strobe from the CPU stops only the CPU enable. The peripheral enable keeps its current rate, divided or not. While the CPU sleeps, the block forces the core's 2-bit interrupt mask field to `10`, which enables all interrupts. The CPU wakes when the interrupt-pending line rises or when reset is applied. A write to the configuration is held in a staging register. It takes effect only at a peripheral-enable boundary, so no enable period is ever cut short.

Every pin is a plain control or status signal. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `clkpm_ctrl`

## Requirements
- R1: While reset is low and on the first cycles after it, the block is in Run mode (mode `00`). `cpu_ce_o` and `per_ce_o` are both high and the mask override is inactive. Reset also clears the stored slow-enable bit and the divider code.
- R2: In Run mode (slow disabled), `per_ce_o` is high on every cycle.
- R3: In Slow mode, `per_ce_o` is high on one cycle out of every N. N is 2 for code `00`, 4 for `01`, 8 for `10` and 16 for `11`.
- R4: Outside wait, `cpu_ce_o` equals `per_ce_o` on every cycle, in both Run and Slow.
- R5: A configuration write is stored at the clock edge where `cfg_we_i` is high. It becomes active at the first later edge that ends a cycle with `per_ce_o` high, and the divider count restarts there. If such an edge coincides with a write, the previously stored value is applied.
- R6: A `wfi_i` pulse with `irq_pend_i` low enters wait at the next edge. From then on `cpu_ce_o` is low, and `per_ce_o` keeps its rate.
- R7: While waiting, `imask_force_o` is 1 and `imask_val_o` is `10`. At all other times `imask_force_o` is 0 and `imask_val_o` is `00`.
- R8: While waiting, a high `irq_pend_i` leaves wait at the next edge and restores `cpu_ce_o`.
- R9: If `irq_pend_i` is high in the same cycle as `wfi_i`, wait is not entered.
- R10: Wait entered while Slow is active gives Slow-wait (mode `11`). In Slow-wait, `per_ce_o` keeps the divided rate.
- R11: `mode_o` bit 0 is 1 when the divided rate is active, and bit 1 is 1 when the CPU is waiting. This gives `00` Run, `01` Slow, `10` Wait and `11` Slow-wait.
- R12: Reset applied while waiting leaves wait at once and returns the block to Run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the mode configuration |
| cfg_slow_en_i | input | 1 | Slow-mode enable value to store |
| cfg_div_sel_i | input | 2 | Divider code to store (00:/2, 01:/4, 10:/8, 11:/16) |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the CPU |
| irq_pend_i | input | 1 | An interrupt is pending |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| mode_o | output | 2 | Current mode (bit0 slow, bit1 wait) |
| imask_force_o | output | 1 | Override of the core interrupt mask is active |
| imask_val_o | output | 2 | Value forced onto the interrupt mask field |

## Verification
All outputs come straight from registers, so every result of a stimulus is due one edge after that stimulus. This holds for wait entry, wait exit, the cancel case and the staging of a write. The one exception is a configuration change: its new rate appears only at the edge that ends the current enable period, which can be up to 16 cycles later. The bench drives inputs just after the falling edge and advances a behavioural model at each rising edge. It compares every output against that model at the next falling edge, so each result is checked in the exact cycle it falls due.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN       = 2'b00,
    MODE_SLOW      = 2'b01,
    MODE_WAIT      = 2'b10,
    MODE_SLOW_WAIT = 2'b11
  } clkpm_mode_e;

  typedef struct packed {
    logic       slow_en;
    logic [1:0] sel;
  } clkpm_cfg_t;

  function automatic clkpm_mode_e clkpm_mode(input logic waiting, input logic slow);
    return clkpm_mode_e'({waiting, slow});
  endfunction

endpackage

// File: rtl/clkpm_cfg_stage.sv
module clkpm_cfg_stage
  import clkpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  clkpm_cfg_t wdata_i,
  input  logic       apply_i,
  output clkpm_cfg_t active_o
);

  clkpm_cfg_t pend_q;
  clkpm_cfg_t act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (we_i) begin
      pend_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (apply_i) begin
      act_q <= pend_q;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/clkpm_div.sv
module clkpm_div #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int unsigned NCODE = 1 << SEL_W;
  localparam int unsigned CNT_W = NCODE;

  logic [CNT_W-1:0] last_tbl [NCODE];
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NCODE; g++) begin : g_ratio
    assign last_tbl[g] = CNT_W'((64'd2 << g) - 64'd1);
  end

  assign last_cnt = slow_en_i ? last_tbl[sel_i] : '0;
  assign tick_o   = (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkpm_wait_ctl.sv
module clkpm_wait_ctl #(
  parameter int unsigned       MASK_W    = 2,
  parameter logic [MASK_W-1:0] WAIT_MASK = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_i,
  input  logic              irq_pend_i,
  output logic              waiting_o,
  output logic              mask_force_o,
  output logic [MASK_W-1:0] mask_val_o
);

  logic wait_q;
  logic wait_d;

  always_comb begin
    wait_d = wait_q;
    if (wait_q) begin
      if (irq_pend_i) wait_d = 1'b0;
    end else if (wfi_i && !irq_pend_i) begin
      wait_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
    end
  end

  assign waiting_o    = wait_q;
  assign mask_force_o = wait_q;
  assign mask_val_o   = wait_q ? WAIT_MASK : '0;

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned MASK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_slow_en_i,
  input  logic [SEL_W-1:0]  cfg_div_sel_i,
  input  logic              wfi_i,
  input  logic              irq_pend_i,
  output logic              cpu_ce_o,
  output logic              per_ce_o,
  output logic [1:0]        mode_o,
  output logic              imask_force_o,
  output logic [MASK_W-1:0] imask_val_o
);

  clkpm_cfg_t  wdata;
  clkpm_cfg_t  active;
  logic        tick;
  logic        waiting;
  clkpm_mode_e mode;

  assign wdata.slow_en = cfg_slow_en_i;
  assign wdata.sel     = cfg_div_sel_i;

  clkpm_cfg_stage i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (wdata),
    .apply_i  (tick),
    .active_o (active)
  );

  clkpm_div #(.SEL_W(SEL_W)) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_en_i (active.slow_en),
    .sel_i     (active.sel),
    .tick_o    (tick)
  );

  clkpm_wait_ctl #(.MASK_W(MASK_W), .WAIT_MASK(MASK_W'(2))) i_wait (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wfi_i        (wfi_i),
    .irq_pend_i   (irq_pend_i),
    .waiting_o    (waiting),
    .mask_force_o (imask_force_o),
    .mask_val_o   (imask_val_o)
  );

  assign mode     = clkpm_mode(waiting, active.slow_en);
  assign mode_o   = mode;
  assign per_ce_o = tick;
  assign cpu_ce_o = tick && !waiting;

endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned MASK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wfi_i,
  input logic              irq_pend_i,
  input logic              cpu_ce_o,
  input logic              per_ce_o,
  input logic [1:0]        mode_o,
  input logic              imask_force_o,
  input logic [MASK_W-1:0] imask_val_o
);

  AST_WAIT_STOPS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> !cpu_ce_o); // R6

  AST_WAIT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> (imask_force_o && imask_val_o == MASK_W'(2))); // R7

  AST_NO_MASK_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[1] |-> (!imask_force_o && imask_val_o == '0)); // R7

  AST_WAIT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wfi_i && !irq_pend_i && !mode_o[1]) |=> mode_o[1]); // R6

  AST_WAIT_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wfi_i && irq_pend_i && !mode_o[1]) |=> !mode_o[1]); // R9

  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && irq_pend_i) |=> !mode_o[1]); // R8

  AST_RUN_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[0] |-> per_ce_o); // R2

  AST_SLOW_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[0] && per_ce_o) |=> (!per_ce_o || !mode_o[0])); // R3

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[0] != $past(mode_o[0])) |-> $past(per_ce_o)); // R5

  AST_CPU_FOLLOWS_PER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[1] |-> (cpu_ce_o == per_ce_o)); // R4

endmodule

bind clkpm_ctrl clkpm_ctrl_chk #(.SEL_W(SEL_W), .MASK_W(MASK_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wfi_i         (wfi_i),
  .irq_pend_i    (irq_pend_i),
  .cpu_ce_o      (cpu_ce_o),
  .per_ce_o      (per_ce_o),
  .mode_o        (mode_o),
  .imask_force_o (imask_force_o),
  .imask_val_o   (imask_val_o)
);

// File: tb/test_clkpm_ctrl.sv
module test_clkpm_ctrl;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic       cfg_slow_en_i = 1'b0;
  logic [1:0] cfg_div_sel_i = 2'b00;
  logic       wfi_i = 1'b0;
  logic       irq_pend_i = 1'b0;
  logic       cpu_ce_o;
  logic       per_ce_o;
  logic [1:0] mode_o;
  logic       imask_force_o;
  logic [1:0] imask_val_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int  m_cnt = 0;
  bit  m_en = 0;
  int  m_sel = 0;
  bit  m_pen = 0;
  int  m_psel = 0;
  bit  m_wait = 0;

  always #2 clk_i = ~clk_i;

  clkpm_ctrl i_clkpm_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_slow_en_i (cfg_slow_en_i),
    .cfg_div_sel_i (cfg_div_sel_i),
    .wfi_i         (wfi_i),
    .irq_pend_i    (irq_pend_i),
    .cpu_ce_o      (cpu_ce_o),
    .per_ce_o      (per_ce_o),
    .mode_o        (mode_o),
    .imask_force_o (imask_force_o),
    .imask_val_o   (imask_val_o)
  );

  function automatic int ratio();
    return m_en ? (2 << m_sel) : 1;
  endfunction

  function automatic bit m_tick();
    return m_cnt == ratio() - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model advances on the same edge as the design
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_en = 0; m_sel = 0; m_pen = 0; m_psel = 0; m_wait = 0;
    end else begin
      bit t;
      t = m_tick();
      if (t) begin
        m_en = m_pen; m_sel = m_psel; m_cnt = 0;
      end else begin
        m_cnt++;
      end
      if (cfg_we_i) begin
        m_pen = cfg_slow_en_i; m_psel = int'(cfg_div_sel_i);
      end
      if (m_wait) begin
        if (irq_pend_i) m_wait = 0;
      end else if (wfi_i && !irq_pend_i) begin
        m_wait = 1;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      bit exp_per;
      exp_per = m_tick();
      cycles++;
      chk(per_ce_o == exp_per, m_en ? "R3 per_ce slow rate" : "R2 per_ce run rate",
          int'(per_ce_o), int'(exp_per));
      chk(cpu_ce_o == (exp_per && !m_wait), m_wait ? "R6 cpu_ce gated" : "R4 cpu_ce",
          int'(cpu_ce_o), int'(exp_per && !m_wait));
      chk(mode_o == {m_wait, m_en}, "R11 mode", int'(mode_o), int'({m_wait, m_en}));
      chk(imask_force_o == m_wait && imask_val_o == (m_wait ? 2'b10 : 2'b00),
          "R7 mask override", int'({imask_force_o, imask_val_o}),
          int'({m_wait, m_wait ? 2'b10 : 2'b00}));
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic write_cfg(input bit en, input logic [1:0] sel);
    cfg_we_i = 1'b1; cfg_slow_en_i = en; cfg_div_sel_i = sel;
    cyc();
    cfg_we_i = 1'b0;
  endtask

  task automatic wfi_pulse(input bit irq);
    wfi_i = 1'b1; irq_pend_i = irq;
    cyc();
    wfi_i = 1'b0; irq_pend_i = 1'b0;
  endtask

  task automatic irq_pulse();
    irq_pend_i = 1'b1;
    cyc();
    irq_pend_i = 1'b0;
  endtask

  // spacing of per_ce pulses measured directly at the ports
  task automatic measure_gap(input int exp, input string req);
    int gap;
    while (!per_ce_o) cyc();
    gap = 0;
    do begin
      cyc(); gap++;
    end while (!per_ce_o && gap < 40);
    chk(gap == exp, req, gap, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(3);
    chk(mode_o == 2'b00 && cpu_ce_o && per_ce_o && !imask_force_o, "R1 reset state",
        int'({mode_o, cpu_ce_o, per_ce_o, imask_force_o}), 6);
    rst_ni = 1'b1;
    cyc(5);
    chk(mode_o == 2'b00, "R1 run after reset", int'(mode_o), 0);

    // R3 / R4: each divider code
    for (int c = 0; c < 4; c++) begin
      write_cfg(1'b1, 2'(c));
      cyc(40);
      measure_gap(2 << c, "R3 measured divide ratio");
    end

    // R5: a write mid-period waits for the boundary
    write_cfg(1'b1, 2'b11);
    cyc(40);
    while (!per_ce_o) cyc();
    cyc(3);
    write_cfg(1'b1, 2'b00);
    chk(mode_o == 2'b01 && !per_ce_o, "R5 old rate held", int'(per_ce_o), 0);
    cyc(20);

    // R10: slow-wait keeps divided peripheral rate
    write_cfg(1'b1, 2'b01);
    cyc(10);
    wfi_pulse(1'b0);
    chk(mode_o == 2'b11, "R10 slow-wait mode", int'(mode_o), 3);
    measure_gap(4, "R10 divided rate in slow-wait");
    irq_pulse();
    chk(mode_o == 2'b01, "R8 exit slow-wait", int'(mode_o), 1);

    // R6 / R8: wait in run mode
    write_cfg(1'b0, 2'b00);
    cyc(10);
    wfi_pulse(1'b0);
    chk(mode_o == 2'b10 && !cpu_ce_o && per_ce_o, "R6 wait entry",
        int'({mode_o, cpu_ce_o, per_ce_o}), 9);
    cyc(6);
    irq_pulse();
    chk(mode_o == 2'b00 && cpu_ce_o, "R8 wake on irq", int'({mode_o, cpu_ce_o}), 1);

    // R9: irq in the same cycle cancels entry
    wfi_pulse(1'b1);
    chk(mode_o == 2'b00 && cpu_ce_o, "R9 entry cancelled", int'({mode_o, cpu_ce_o}), 1);
    cyc(3);

    // R12: reset while waiting in slow mode
    write_cfg(1'b1, 2'b10);
    cyc(20);
    wfi_pulse(1'b0);
    cyc(4);
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(2);
    chk(mode_o == 2'b00 && cpu_ce_o && per_ce_o, "R12 reset leaves wait",
        int'({mode_o, cpu_ce_o, per_ce_o}), 3);
    cyc(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule